// File: doc/BRIEF.md
# Packed INT16 Pair Dot-Product Accumulator

This block is a wide vector arithmetic unit that works on sixteen independent 32-bit lanes at once. Each lane of the two source operands is read as two signed 16-bit integers. The lane multiplies the low halves together and the high halves together, then adds both products to a signed 32-bit accumulator lane. The sum is returned as the new 32-bit lane value. A single control bit picks how the final add behaves: it either wraps modulo 2^32 or clamps to the signed 32-bit range.

A per-lane write-enable vector merges the new values with the old accumulator. A lane whose enable is clear passes its accumulator input through unchanged. The result is registered one clock after an accepted operation, and an output valid flag marks it. Between operations the registered result holds its value. The reset input is asynchronous and active low; its release is synchronised inside the block.

Top module: `pair_dot_acc`

## Requirements
- R1: Lane i occupies bits [32i+31:32i] of each 512-bit operand. Within a lane, bits [15:0] hold the first signed 16-bit element and bits [31:16] hold the second.
- R2: For a written lane, result = acc + a_lo*b_lo + a_hi*b_hi, with every operand and product treated as signed.
- R3: When sat_en=0, the final add wraps. The lane result is the exact sum taken modulo 2^32.
- R4: When sat_en=1 and the exact sum exceeds 2^31-1, the lane result is 0x7FFFFFFF. When sat_en=1 and the exact sum is below -2^31, the lane result is 0x80000000.
- R5: When sat_en=1 and the exact sum fits in 32 signed bits, the lane result equals the result of wrap mode.
- R6: The product (-32768)*(-32768) is taken exactly as +2^30, including when both halves of a lane use it.
- R7: A lane whose wr_mask bit is 0 outputs its acc_in lane unchanged, in either mode.
- R8: The result appears on `result` one clock edge after in_valid=1 is sampled. out_valid is in_valid delayed by one clock.
- R9: While in_valid=0, `result` keeps its last value, whatever the operand inputs do.
- R10: After reset, out_valid=0 and result=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| sat_en | input | 1 | 1 = saturating final add, 0 = wrapping |
| wr_mask | input | 16 | Per-lane write enable; 0 keeps the accumulator lane |
| acc_in | input | 512 | Accumulator operand, 16 lanes of 32 bits |
| src_a | input | 512 | First source, two signed 16-bit elements per lane |
| src_b | input | 512 | Second source, two signed 16-bit elements per lane |
| out_valid | output | 1 | Registered result is valid |
| result | output | 512 | Registered lane results |

## Verification
The bench targets four kinds of corner case:
- **Both overflow directions in saturating mode.** It drives a positive accumulator at the top of the range and a large negative accumulator with negative products. A design that clamps on the wrong bits would return a wrapped value of the opposite sign, or clamp results that are still in range.
- **The -32768 squared product in both halves.** A design that forms the product at 16 or 31 bits would return a negative or truncated value.
- **Lane placement and half placement.** It puts data in one lane, and in only the upper halves. A design that swaps halves or lanes would write the value in the wrong place.
- **Masked lanes and idle cycles.** It changes the inputs on idle cycles and checks that they are ignored. A design that leaks the computed sum into a masked lane, or updates the result without a valid input, would show it at the output.

// File: rtl/pdot_pkg.sv
package pdot_pkg;
  parameter int unsigned LANES   = 16;
  parameter int unsigned LANE_W  = 32;
  localparam int unsigned ELEM_W = LANE_W / 2;
  localparam int unsigned SUM_W  = LANE_W + 2;
  localparam int unsigned VEC_W  = LANES * LANE_W;
endpackage

// File: rtl/pdot_clamp.sv
module pdot_clamp #(
  parameter int unsigned IN_W  = 34,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  sum_i,
  input  logic             sat_en,
  output logic [OUT_W-1:0] res_o
);
  localparam int unsigned TOP_N = IN_W - OUT_W + 1;

  logic [TOP_N-1:0] top_bits;
  logic             fits;
  logic [OUT_W-1:0] max_pos;
  logic [OUT_W-1:0] max_neg;

  always_comb begin
    top_bits = sum_i[IN_W-1:OUT_W-1];
    fits     = (top_bits == '0) || (top_bits == '1);
    max_pos  = {1'b0, {(OUT_W-1){1'b1}}};
    max_neg  = {1'b1, {(OUT_W-1){1'b0}}};
    if (sat_en && !fits) begin
      res_o = sum_i[IN_W-1] ? max_neg : max_pos;
    end else begin
      res_o = sum_i[OUT_W-1:0];
    end
  end

  // Saturated output sign always matches the wide sum sign
  always_comb begin
    if (sat_en) begin
      AST_SAT_SIGN: assert (res_o[OUT_W-1] == sum_i[IN_W-1]); // R4
    end
  end
endmodule

// File: rtl/pdot_lane.sv
module pdot_lane
  import pdot_pkg::*;
(
  input  logic [LANE_W-1:0] acc_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              sat_en,
  input  logic              wr_en,
  output logic [LANE_W-1:0] res_o
);
  logic signed [ELEM_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic signed [LANE_W-1:0] prod_lo, prod_hi;
  logic signed [SUM_W-1:0]  sum_w;
  logic [LANE_W-1:0]        clamped;

  always_comb begin
    a_lo    = a_i[ELEM_W-1:0];
    a_hi    = a_i[LANE_W-1:ELEM_W];
    b_lo    = b_i[ELEM_W-1:0];
    b_hi    = b_i[LANE_W-1:ELEM_W];
    prod_lo = a_lo * b_lo;
    prod_hi = a_hi * b_hi;
    sum_w   = $signed({{(SUM_W-LANE_W){acc_i[LANE_W-1]}}, acc_i})
            + $signed({{(SUM_W-LANE_W){prod_lo[LANE_W-1]}}, prod_lo})
            + $signed({{(SUM_W-LANE_W){prod_hi[LANE_W-1]}}, prod_hi});
  end

  pdot_clamp #(.IN_W(SUM_W), .OUT_W(LANE_W)) u_clamp (
    .sum_i (sum_w),
    .sat_en(sat_en),
    .res_o (clamped)
  );

  always_comb begin
    res_o = wr_en ? clamped : acc_i;
  end

  // Most-negative squared must come out positive
  always_comb begin
    if (a_lo == {1'b1, {(ELEM_W-1){1'b0}}} && b_lo == {1'b1, {(ELEM_W-1){1'b0}}}) begin
      AST_MINSQ_POS: assert (!prod_lo[LANE_W-1] && prod_lo != '0); // R6
    end
  end
endmodule

// File: rtl/pair_dot_acc.sv
module pair_dot_acc
  import pdot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             sat_en,
  input  logic [15:0]      wr_mask,
  input  logic [511:0]     acc_in,
  input  logic [511:0]     src_a,
  input  logic [511:0]     src_b,
  output logic             out_valid,
  output logic [511:0]     result
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [VEC_W-1:0] lane_res;
  logic [VEC_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;

  // Reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pdot_lane u_lane (
      .acc_i (acc_in[g*LANE_W +: LANE_W]),
      .a_i   (src_a[g*LANE_W +: LANE_W]),
      .b_i   (src_b[g*LANE_W +: LANE_W]),
      .sat_en(sat_en),
      .wr_en (wr_mask[g]),
      .res_o (lane_res[g*LANE_W +: LANE_W])
    );

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_int_n)
      (in_valid && !wr_mask[g]) |=> (result[g*LANE_W +: LANE_W] == $past(acc_in[g*LANE_W +: LANE_W]))); // R7
  end

  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? lane_res : res_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(result)); // R9
endmodule

// File: tb/tb_pair_dot_acc.sv
module tb_pair_dot_acc;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, sat_en;
  logic [15:0]  wr_mask;
  logic [511:0] acc_in, src_a, src_b;
  logic         out_valid;
  logic [511:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pair_dot_acc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sat_en(sat_en),
    .wr_mask(wr_mask), .acc_in(acc_in), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] ref_lane(logic [31:0] c, logic [31:0] a,
                                           logic [31:0] b, logic sat, logic m);
    longint s;
    if (!m) return c;
    s = longint'($signed(c))
      + longint'($signed(a[15:0])) * longint'($signed(b[15:0]))
      + longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
    if (sat) begin
      if (s > 64'sd2147483647) s = 64'sd2147483647;
      if (s < -64'sd2147483648) s = -64'sd2147483648;
    end
    return s[31:0];
  endfunction

  function automatic logic [511:0] ref_vec(logic [511:0] c, logic [511:0] a,
                                           logic [511:0] b, logic sat, logic [15:0] m);
    logic [511:0] r;
    for (int i = 0; i < 16; i++)
      r[i*32 +: 32] = ref_lane(c[i*32 +: 32], a[i*32 +: 32], b[i*32 +: 32], sat, m[i]);
    return r;
  endfunction

  task automatic check(string tag, logic [511:0] got, logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Called at a negedge; applies one op, checks at the following negedge
  task automatic run_op(string tag, logic [511:0] c, logic [511:0] a,
                        logic [511:0] b, logic sat, logic [15:0] m);
    acc_in = c; src_a = a; src_b = b; sat_en = sat; wr_mask = m; in_valid = 1'b1;
    @(negedge clk);
    check({tag, " valid R8"}, {511'd0, out_valid}, 512'd1);
    check(tag, result, ref_vec(c, a, b, sat, m));
    in_valid = 1'b0;
  endtask

  function automatic logic [511:0] rnd_vec(int mode);
    logic [511:0] v;
    for (int i = 0; i < 32; i++) begin
      logic [15:0] h;
      case (mode == 0 ? 0 : $urandom_range(0, 3))
        0: h = 16'($urandom);
        1: h = 16'h8000;
        2: h = 16'h7FFF;
        default: h = 16'hFFFF;
      endcase
      v[i*16 +: 16] = h;
    end
    return v;
  endfunction

  function automatic logic [511:0] fill(logic [31:0] x);
    return {16{x}};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [511:0] held, a1;
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 0; sat_en = 0; wr_mask = '0;
    acc_in = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    check("R10 reset result", result, '0);
    check("R10 reset valid", {511'd0, out_valid}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release", result, '0);

    // R1: one lane, upper halves only
    a1 = '0; a1[5*32 +: 32] = 32'h0003_0000;
    held = '0; held[5*32 +: 32] = 32'h0007_0000;
    run_op("R1 lane5 hi half", '0, a1, held, 1'b0, 16'hFFFF);
    check("R1 lane5 value", {480'd0, result[5*32 +: 32]}, 512'd21);
    // R2 basic signed
    run_op("R2 signed mix", fill(32'd100), fill(32'hFFFE_0003), fill(32'h0005_FFF9), 1'b0, 16'hFFFF);
    // R6 min squared, both halves
    run_op("R6 min sq wrap", '0, fill(32'h8000_8000), fill(32'h8000_8000), 1'b0, 16'hFFFF);
    check("R6 lane0 2^31 wraps", {480'd0, result[31:0]}, {480'd0, 32'h8000_0000});
    run_op("R6 min sq sat", '0, fill(32'h8000_8000), fill(32'h8000_8000), 1'b1, 16'hFFFF);
    check("R6 lane0 sat max", {480'd0, result[31:0]}, {480'd0, 32'h7FFF_FFFF});
    // R3/R4 overflow both ways
    run_op("R3 pos wrap", fill(32'h7FFF_FFFF), fill(32'h0001_0001), fill(32'h0001_0001), 1'b0, 16'hFFFF);
    check("R3 lane0 wrapped", {480'd0, result[31:0]}, {480'd0, 32'h8000_0001});
    run_op("R4 pos sat", fill(32'h7FFF_FFFF), fill(32'h0001_0001), fill(32'h0001_0001), 1'b1, 16'hFFFF);
    check("R4 lane0 max", {480'd0, result[31:0]}, {480'd0, 32'h7FFF_FFFF});
    run_op("R4 neg sat", fill(32'h8000_0005), fill(32'h7FFF_7FFF), fill(32'h8000_8000), 1'b1, 16'hFFFF);
    check("R4 lane0 min", {480'd0, result[31:0]}, {480'd0, 32'h8000_0000});
    // R5 in-range sat equals wrap
    run_op("R5 in range sat", fill(32'hFFFF_FF00), fill(32'h0010_0020), fill(32'h0002_0003), 1'b1, 16'hFFFF);
    // R7 mask
    run_op("R7 mask mix", fill(32'h1234_5678), fill(32'h7FFF_7FFF), fill(32'h7FFF_7FFF), 1'b1, 16'hA5C3);
    check("R7 lane2 kept", {480'd0, result[2*32 +: 32]}, {480'd0, 32'h1234_5678});
    // R9 hold on idle with changing inputs
    held = result;
    acc_in = fill(32'hDEAD_BEEF); src_a = fill(32'h1111_2222); wr_mask = 16'hFFFF;
    @(negedge clk);
    check("R9 hold idle", result, held);
    check("R8 idle valid low", {511'd0, out_valid}, '0);

    // Random ops
    for (int n = 0; n < 400; n++) begin
      run_op("R2 R3 R4 R7 random", rnd_vec(n % 2), rnd_vec(n % 3), rnd_vec(n % 2),
             1'($urandom), 16'($urandom));
      if (n % 7 == 0) begin
        held = result;
        src_b = rnd_vec(0);
        @(negedge clk);
        check("R9 random idle", result, held);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule